// File: doc/BRIEF.md
# Video Line Statistics Monitor

This block observes a video timing stream in the pixel clock domain. The stream is a frame-valid strobe and a line-valid strobe. At the close of every frame it produces two 16-bit results. One is the number of lines the frame held. The other is how many pixel clocks the last line of that frame lasted.

Software reads the results one byte at a time through a small register port. Reading a high byte captures the matching low byte, so a 16-bit value read in two steps never mixes bytes from two different frames.

Each result has a change interrupt with its own enable. While an enabled interrupt is pending, its result is frozen, so software sees the value that raised the interrupt. The freeze ends when software completes a high-then-low read of that result.

Top module: `vline_stats_mon`

## Requirements
- R1: After reset both results read as zero at every byte address, and both interrupt outputs are low.
- R2: The line-count result is updated on the clock edge that first samples `frame_vld` low after it was high. Its new value is the number of rising edges of `line_vld` seen while `frame_vld` was high in that frame.
- R3: The line-length result is updated on the same clock edge as the line count. Its new value is the number of cycles in which both `frame_vld` and `line_vld` were high during the last line of the frame, even when earlier lines of that frame had other lengths.
- R4: The line and pixel counters stop at 0xFFFF instead of wrapping, so a line longer than 65535 cycles reports 0xFFFF.
- R5: `rd_data` holds the addressed byte on the cycle after `rd_en` is sampled high. The address map is: 0 = line-count high byte, 1 = line-count low byte, 2 = line-length high byte, 3 = line-length low byte.
- R6: `irq_count` is set at a frame end when `ie_count` is high and the new line count differs from the held line count. It stays low when the new value equals the held value, and it also stays low while `ie_count` is low. `irq_len` follows the same rule for the line length.
- R7: While `ie_count` and `irq_count` are both high, the line-count result does not change at frame ends. A read of address 1 that follows a read of address 0 clears `irq_count` and ends the freeze.
- R8: While `ie_len` and `irq_len` are both high, the line-length result does not change at frame ends. A read of address 3 that follows a read of address 2 clears `irq_len` and ends the freeze.
- R9: A read of a high-byte address captures the matching low byte. The next read of that low-byte address returns the captured byte, even if the result changed between the two reads.
- R10: A low-byte read with no high-byte read before it returns the live low byte and leaves the interrupt flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | High for the duration of a frame |
| line_vld | input | 1 | High while pixels of a line are active |
| ie_count | input | 1 | Line-count change interrupt enable |
| ie_len | input | 1 | Line-length change interrupt enable |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register byte address |
| rd_data | output | 8 | Read data, valid one cycle after the strobe |
| irq_count | output | 1 | Line-count change interrupt |
| irq_len | output | 1 | Line-length change interrupt |

## Verification
The assertions assume that `line_vld` is high only while `frame_vld` is high. They also assume that interrupt enables change only while no interrupt is pending, because a flag may only fall as the result of a completing low-byte read. The directed frames always raise `line_vld` after `frame_vld` and drop it before `frame_vld` falls, and each frame keeps idle gaps between lines. The enables are changed only after both flags have been cleared by reads.

// File: rtl/vline_stats_mon.sv
module vline_stats_mon #(
  parameter int unsigned RES_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_vld,
  input  logic       line_vld,
  input  logic       ie_count,
  input  logic       ie_len,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq_count,
  output logic       irq_len
);
  localparam logic [RES_W-1:0] MAXV = '1;

  logic             fv_q, lv_q;
  logic [RES_W-1:0] line_acc, pix_acc, res_cnt, res_len;
  logic             cnt_armed, len_armed;
  logic [7:0]       cnt_shadow, len_shadow;

  wire frame_end  = fv_q & ~frame_vld;
  wire line_start = frame_vld & line_vld & ~lv_q;
  wire pix_on     = frame_vld & line_vld;

  wire rd_cnt_hi = rd_en & (rd_addr == 2'd0);
  wire rd_cnt_lo = rd_en & (rd_addr == 2'd1);
  wire rd_len_hi = rd_en & (rd_addr == 2'd2);
  wire rd_len_lo = rd_en & (rd_addr == 2'd3);

  wire cnt_upd   = frame_end & ~(ie_count & irq_count);
  wire len_upd   = frame_end & ~(ie_len & irq_len);
  wire cnt_clear = rd_cnt_lo & cnt_armed;
  wire len_clear = rd_len_lo & len_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q <= 1'b0;
      lv_q <= 1'b0;
    end else begin
      fv_q <= frame_vld;
      lv_q <= line_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_acc <= '0;
      pix_acc  <= '0;
    end else if (frame_end) begin
      line_acc <= '0;
      pix_acc  <= '0;
    end else begin
      if (line_start && line_acc != MAXV) line_acc <= line_acc + 1'b1;
      if (pix_on) begin
        if (line_start)          pix_acc <= {{(RES_W-1){1'b0}}, 1'b1};
        else if (pix_acc != MAXV) pix_acc <= pix_acc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_cnt   <= '0;
      irq_count <= 1'b0;
    end else begin
      if (cnt_upd) res_cnt <= line_acc;
      if (cnt_upd && ie_count && line_acc != res_cnt) irq_count <= 1'b1;
      else if (cnt_clear)                            irq_count <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_len <= '0;
      irq_len <= 1'b0;
    end else begin
      if (len_upd) res_len <= pix_acc;
      if (len_upd && ie_len && pix_acc != res_len) irq_len <= 1'b1;
      else if (len_clear)                         irq_len <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_armed  <= 1'b0;
      len_armed  <= 1'b0;
      cnt_shadow <= '0;
      len_shadow <= '0;
    end else begin
      if (rd_cnt_hi) begin
        cnt_armed  <= 1'b1;
        cnt_shadow <= res_cnt[7:0];
      end else if (rd_cnt_lo) begin
        cnt_armed  <= 1'b0;
      end
      if (rd_len_hi) begin
        len_armed  <= 1'b1;
        len_shadow <= res_len[7:0];
      end else if (rd_len_lo) begin
        len_armed  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        2'd0:    rd_data <= res_cnt[15:8];
        2'd1:    rd_data <= cnt_armed ? cnt_shadow : res_cnt[7:0];
        2'd2:    rd_data <= res_len[15:8];
        default: rd_data <= len_armed ? len_shadow : res_len[7:0];
      endcase
    end
  end
endmodule

module vline_stats_mon_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_vld,
  input logic        fv_q,
  input logic        ie_count,
  input logic        ie_len,
  input logic        irq_count,
  input logic        irq_len,
  input logic        rd_en,
  input logic [1:0]  rd_addr,
  input logic        cnt_armed,
  input logic [15:0] line_acc,
  input logic [15:0] pix_acc,
  input logic [15:0] res_cnt,
  input logic [15:0] res_len
);
  assert_line_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_acc == 16'hFFFF && !(fv_q && !frame_vld)) |=> line_acc == 16'hFFFF);

  assert_pix_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_acc == 16'hFFFF && !(fv_q && !frame_vld)) |=> pix_acc == 16'hFFFF);

  assert_cnt_only_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fv_q && !frame_vld) |=> $stable(res_cnt));

  assert_len_only_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fv_q && !frame_vld) |=> $stable(res_len));

  assert_cnt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_count && irq_count) |=> $stable(res_cnt));

  assert_len_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_len && irq_len) |=> $stable(res_len));

  assert_irq_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_count) |-> ($past(fv_q) && !$past(frame_vld)));

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_count) |-> ($past(rd_en) && $past(rd_addr) == 2'd1 && $past(cnt_armed)));
endmodule

bind vline_stats_mon vline_stats_mon_chk u_chk (.*);

// File: tb/test_vline_stats_mon.sv
module test_vline_stats_mon;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_vld = 1'b0, line_vld = 1'b0;
  logic       ie_count = 1'b0, ie_len = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       irq_count, irq_len;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vline_stats_mon i_vline_stats_mon (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd16(input logic [1:0] hi_a, output int v);
    logic [7:0] h, l;
    rd(hi_a, h);
    rd(hi_a + 2'd1, l);
    v = {h, l};
  endtask

  task automatic frame(input int n, input int len, input int last);
    @(negedge clk); frame_vld = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      line_vld = 1'b1;
      repeat ((i == n-1) ? last : len) @(negedge clk);
      line_vld = 1'b0;
      repeat (2) @(negedge clk);
    end
    frame_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reset byte", d, 0);
    end
    chk("R1 irq_count reset", irq_count, 0);
    chk("R1 irq_len reset", irq_len, 0);
  endtask

  task automatic t_basic();
    int v;
    frame(3, 5, 7);
    rd16(2'd0, v); chk("R2 line count", v, 3);
    rd16(2'd2, v); chk("R3 last line length", v, 7);
    chk("R6 no irq_count when disabled", irq_count, 0);
    chk("R6 no irq_len when disabled", irq_len, 0);
    frame(2, 4, 4);
    rd16(2'd0, v); chk("R5 R2 count address map", v, 2);
    rd16(2'd2, v); chk("R5 R3 length address map", v, 4);
  endtask

  task automatic t_irq();
    int v;
    logic [7:0] d;
    ie_count = 1'b1; ie_len = 1'b1;
    frame(4, 6, 6);
    chk("R6 irq_count on change", irq_count, 1);
    chk("R6 irq_len on change", irq_len, 1);
    frame(2, 9, 9);
    rd16(2'd0, v); chk("R7 count frozen", v, 4);
    chk("R7 irq_count cleared by hi/lo read", irq_count, 0);
    chk("R8 irq_len kept by other reads", irq_len, 1);
    rd16(2'd2, v); chk("R8 length frozen", v, 6);
    chk("R8 irq_len cleared by hi/lo read", irq_len, 0);
    frame(4, 6, 6);
    chk("R6 no irq_count on equal value", irq_count, 0);
    chk("R6 no irq_len on equal value", irq_len, 0);
    frame(5, 3, 3);
    chk("R6 irq_count set again", irq_count, 1);
    rd(2'd1, d); chk("R10 lone low read live value", d, 5);
    chk("R10 lone low read keeps irq", irq_count, 1);
    rd16(2'd0, v); chk("R7 count after unfreeze", v, 5);
    chk("R7 irq_count cleared", irq_count, 0);
    rd16(2'd2, v); chk("R8 length after unfreeze", v, 3);
    chk("R8 irq_len cleared", irq_len, 0);
    ie_count = 1'b0; ie_len = 1'b0;
  endtask

  task automatic t_coherent();
    logic [7:0] d;
    frame(1, 511, 511);
    rd(2'd2, d); chk("R9 high byte before change", d, 8'h01);
    frame(1, 515, 515);
    rd(2'd3, d); chk("R9 low byte latched at high read", d, 8'hFF);
    rd(2'd2, d); chk("R9 new high byte", d, 8'h02);
    rd(2'd3, d); chk("R9 new low byte", d, 8'h03);
  endtask

  task automatic t_sat();
    int v;
    frame(2, 10, 65540);
    rd16(2'd2, v); chk("R4 length saturates", v, 16'hFFFF);
    rd16(2'd0, v); chk("R4 count beside saturated line", v, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_irq();
    t_coherent();
    t_sat();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule